// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock-Enable Suspend

This block is the device side of a single-data-rate synchronous DRAM column path. It holds a small word array and takes a two-bit command each clock: NOP, mode load, READ or WRITE. A programmed mode word sets the burst length, the order of the columns within a burst, the read latency, and whether writes are single-beat. From these the block steps through burst columns, captures write data from the bus, and returns read data after the programmed latency. The data output enable is high only while read beats are on the bus.

A clock-enable input can freeze a burst mid-flight. The block registers the enable on every real clock edge. When a burst or read pipeline is busy and the registered enable is low, the next internal edge is skipped. On a skipped edge the column counter, the read pipeline and the output register all hold, and any command or data on the inputs is dropped. When the engine is idle, the enable has no effect and commands are taken as usual.

Top module: `sdram_burst_engine`

## Requirements
- R1: After reset, dq_oe is 0 and dq_out is 0. The mode is burst length 1, sequential order, read latency 2, and writes that follow the burst length.
- R2: cmd=1 on an active edge loads the mode from addr. Bits 2:0 are the length code: 0,1,2,3 give 1,2,4,8, and any other code gives 1. Bit 3 selects interleaved order when 1. Bits 6:4 equal to 3 give latency 3, and any other value gives latency 2. Bit 9 selects single-beat writes when 1.
- R3: In sequential order, beat i of a burst of length L starting at column s uses column (s - s mod L) + ((s mod L + i) mod L).
- R4: In interleaved order, beat i uses column (s - s mod L) + ((s mod L) XOR i).
- R5: A READ (cmd=2, column on addr) accepted at edge k drives beat i on dq_out with dq_oe=1 in the cycle after edge k+CL-1+i. dq_oe is 0 before that.
- R6: dq_oe falls after the edge that ends the last read beat, and stays 0 until a later read beat.
- R7: A WRITE (cmd=3) accepted at edge k with bit 9 = 0 stores the dq_in sampled at edge k+i into beat i's column, for i from 0 to L-1.
- R8: With bit 9 = 1, a WRITE stores only beat 0, and dq_in on later edges changes nothing. READs still return the full programmed burst.
- R9: A READ or WRITE accepted while a burst runs ends that burst at once. Beats already captured still reach the bus, and the new burst follows with no gap.
- R10: While the engine is busy, cke sampled 0 at edge e makes edge e+1 a frozen edge. On it the burst column does not advance, dq_out and dq_oe hold their values, and cmd, addr and dq_in are ignored.
- R11: cke sampled 1 at edge e makes edge e+1 a normal edge, and the burst resumes from the beat where it stopped.
- R12: While the engine is idle, cke=0 does not block commands: mode loads and WRITEs are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; registered each edge, low freezes a busy burst |
| cmd | input | 2 | 0 NOP, 1 mode load, 2 READ, 3 WRITE |
| addr | input | ADDR_W | Start column for READ/WRITE, mode word for mode load |
| dq_in | input | DATA_W | Write data, one beat per edge |
| dq_out | output | DATA_W | Read data |
| dq_oe | output | 1 | High while a read beat is driven |

## Verification
Read beat i is due in the cycle after edge k+CL-1+i, and the enable falls one edge after the last beat. The bench drives on falling edges, steps one clock at a time, and compares at each falling edge against a column list from its own order functions. Write beats take effect on the edge where they are driven, so they are checked later through reads against a bench copy of the array. For suspend, each edge with cke sampled low adds exactly one edge of hold. The suspend test counts these edges and expects the held beat again before the next one.

// File: rtl/sdram_be_pkg.sv
package sdram_be_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_RD   = 2'd2,
    CMD_WR   = 2'd3
  } be_cmd_e;

  typedef struct packed {
    logic       wr_single;
    logic [2:0] lat_code;
    logic       ilv;
    logic [2:0] len_code;
  } be_mode_t;

  function automatic logic [1:0] len_log2(input logic [2:0] code);
    return code[2] ? 2'd0 : code[1:0];
  endfunction

  function automatic logic lat_is3(input logic [2:0] code);
    return code == 3'd3;
  endfunction

endpackage

// File: rtl/sdram_be_mode.sv
module sdram_be_mode
  import sdram_be_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              load,
  input  logic [ADDR_W-1:0] din,
  output be_mode_t          mode
);

  be_mode_t next_mode;

  always_comb begin
    next_mode.len_code  = din[2:0];
    next_mode.ilv       = din[3];
    next_mode.lat_code  = din[6:4];
    next_mode.wr_single = din[9];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= '0;
    else if (adv && load) mode <= next_mode;
  end

  // R2: a load on an active edge takes effect at that edge
  a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && load) |=> (mode == $past(next_mode)));

endmodule

// File: rtl/sdram_be_seq.sv
module sdram_be_seq
  import sdram_be_pkg::*;
#(
  parameter int COL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             start_rd,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  be_mode_t         mode,
  output logic             active,
  output logic             is_wr,
  output logic [2:0]       beat,
  output logic             last,
  output logic [COL_W-1:0] cur_col
);

  logic [COL_W-1:0] base_q;
  logic [1:0]       l2_q;
  logic             ilv_q;

  function automatic logic [COL_W-1:0] burst_col(
    input logic [COL_W-1:0] s, input logic [2:0] b,
    input logic [1:0] l2, input logic il);
    logic [COL_W-1:0] msk, bx, low;
    msk = COL_W'((32'd1 << l2) - 32'd1);
    bx  = COL_W'(b);
    low = il ? (s ^ bx) : (s + bx);
    return (s & ~msk) | (low & msk);
  endfunction

  assign cur_col = burst_col(base_q, beat, l2_q, ilv_q);
  assign last    = (32'(beat) == ((32'd1 << l2_q) - 32'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      is_wr  <= 1'b0;
      beat   <= '0;
      base_q <= '0;
      l2_q   <= '0;
      ilv_q  <= 1'b0;
    end else if (adv) begin
      if (start_rd || start_wr) begin
        base_q <= start_col;
        l2_q   <= len_log2(mode.len_code);
        ilv_q  <= mode.ilv;
        is_wr  <= start_wr;
        beat   <= start_wr ? 3'd1 : 3'd0;
        active <= start_rd ||
                  ((len_log2(mode.len_code) != 2'd0) && !mode.wr_single);
      end else if (active) begin
        if (last) active <= 1'b0;
        else      beat   <= beat + 3'd1;
      end
    end
  end

  // R3/R4: every burst column stays inside the aligned block of the start column
  a_r3_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (((cur_col ^ base_q) >> l2_q) == '0));

  // R9: a READ restarts the sequencer at beat 0
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && start_rd) |=> (active && !is_wr && beat == 3'd0));

endmodule

// File: rtl/sdram_be_array.sv
module sdram_be_array #(
  parameter int COL_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [COL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [COL_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine
  import sdram_be_pkg::*;
#(
  parameter int COL_W  = 6,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  be_cmd_e           cmd_c;
  be_mode_t          mode;
  logic              cke_q, busy, susp, adv;
  logic              rd_cmd, wr_cmd, ld_cmd;
  logic              seq_active, seq_is_wr, seq_last;
  logic [2:0]        seq_beat;
  logic [COL_W-1:0]  seq_col, start_col, waddr;
  logic [DATA_W-1:0] rdata;
  logic              rd_beat, wr_beat_go, we;
  logic              p1_v, out_v;
  logic [DATA_W-1:0] p1_d, out_d;
  logic              lat3;

  assign cmd_c     = be_cmd_e'(cmd);
  assign rd_cmd    = (cmd_c == CMD_RD);
  assign wr_cmd    = (cmd_c == CMD_WR);
  assign ld_cmd    = (cmd_c == CMD_LOAD);
  assign start_col = addr[COL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  assign busy = seq_active || p1_v || out_v;
  assign susp = busy && !cke_q;
  assign adv  = !susp;

  sdram_be_mode #(.ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(ld_cmd), .din(addr), .mode(mode)
  );

  sdram_be_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .start_rd(rd_cmd), .start_wr(wr_cmd), .start_col(start_col), .mode(mode),
    .active(seq_active), .is_wr(seq_is_wr), .beat(seq_beat),
    .last(seq_last), .cur_col(seq_col)
  );

  assign wr_beat_go = seq_active && seq_is_wr && !rd_cmd && !wr_cmd;
  assign we         = adv && (wr_cmd || wr_beat_go);
  assign waddr      = wr_cmd ? start_col : seq_col;

  sdram_be_array #(.COL_W(COL_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(we), .waddr(waddr), .wdata(dq_in),
    .raddr(seq_col), .rdata(rdata)
  );

  assign rd_beat = seq_active && !seq_is_wr;
  assign lat3    = lat_is3(mode.lat_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_v  <= 1'b0;
      p1_d  <= '0;
      out_v <= 1'b0;
      out_d <= '0;
    end else if (adv) begin
      p1_v <= rd_beat;
      if (rd_beat) p1_d <= rdata;
      out_v <= lat3 ? p1_v : rd_beat;
      if (lat3 ? p1_v : rd_beat) out_d <= lat3 ? p1_d : rdata;
    end
  end

  assign dq_out = out_d;
  assign dq_oe  = out_v;

  // R10: a frozen edge leaves the bus exactly as it was
  a_r10_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
    susp |=> ($stable(dq_out) && $stable(dq_oe)));

  // R10: a frozen edge does not move the burst counter
  a_r10_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    susp |=> ($stable(seq_beat) && $stable(seq_active)));

  // R11: with the enable high, a running burst advances by one beat
  a_r11_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_q && seq_active && !seq_last && !rd_cmd && !wr_cmd)
      |=> (seq_beat == $past(seq_beat) + 3'd1));

  // R8: single-beat write mode leaves no write burst running
  a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wr_cmd && mode.wr_single) |=> !seq_active);

endmodule

// File: tb/tb_sdram_burst_engine.sv
`timescale 1ns/1ps
module tb_sdram_burst_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke;
  logic [1:0]  cmd;
  logic [9:0]  addr;
  logic [15:0] dq_in;
  logic [15:0] dq_out;
  logic        dq_oe;

  int checks = 0;
  int errors = 0;
  logic [15:0] mdl [64];

  int m_bl = 1;
  int m_cl = 2;
  bit m_il = 0;
  bit m_ws = 0;

  always #2 clk = ~clk;

  sdram_burst_engine dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic int exp_col(int s, int i, int bl, bit il);
    int off = s % bl;
    int base = s - off;
    if (il) return base + (off ^ i);
    return base + ((off + i) % bl);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic load_mode(int blc, bit il, int lat, bit ws);
    cmd  = 2'd1;
    addr = 10'((blc & 7) | (int'(il) << 3) | ((lat & 7) << 4) | (int'(ws) << 9));
    step();
    cmd  = 2'd0;
    m_bl = (blc < 4) ? (1 << blc) : 1;
    m_il = il;
    m_cl = (lat == 3) ? 3 : 2;
    m_ws = ws;
  endtask

  task automatic write_burst(int s);
    logic [15:0] d;
    d = 16'($urandom);
    cmd = 2'd3; addr = 10'(s); dq_in = d;
    step();
    mdl[exp_col(s, 0, m_bl, m_il)] = d;
    cmd = 2'd0;
    for (int i = 1; i < m_bl; i++) begin
      d = 16'($urandom);
      dq_in = d;
      step();
      if (!m_ws) mdl[exp_col(s, i, m_bl, m_il)] = d;
    end
  endtask

  task automatic read_chk(int s, string req);
    int c;
    cmd = 2'd2; addr = 10'(s);
    step();
    cmd = 2'd0;
    for (int j = 0; j < m_cl - 1; j++) begin
      chk(dq_oe == 1'b0, "R5 oe before latency", int'(dq_oe), 0);
      step();
    end
    for (int i = 0; i < m_bl; i++) begin
      c = exp_col(s, i, m_bl, m_il);
      chk(dq_oe == 1'b1, req, int'(dq_oe), 1);
      chk(dq_out == mdl[c], req, int'(dq_out), int'(mdl[c]));
      step();
    end
    chk(dq_oe == 1'b0, "R6 oe release", int'(dq_oe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s1, s2, c;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cke = 1'b1; cmd = 2'd0; addr = '0; dq_in = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1: reset state
    chk(dq_oe == 1'b0, "R1 oe after reset", int'(dq_oe), 0);
    chk(dq_out == 16'h0, "R1 dq after reset", int'(dq_out), 0);

    // R1/R7: default mode is burst 1, fill the array
    for (int col = 0; col < 64; col++) write_burst(col);
    read_chk(7, "R1 default single beat read");
    read_chk(42, "R1 default single beat read");

    // R2/R3/R7: burst 4 sequential, latency 2, wrapping start
    load_mode(2, 0, 2, 0);
    write_burst(5);
    read_chk(6, "R3 sequential wrap");
    read_chk(4, "R7 burst write readback");

    // R2/R4: burst 8 interleaved, latency 3
    load_mode(3, 1, 3, 0);
    write_burst(3);
    read_chk(5, "R4 interleaved order");
    read_chk(0, "R5 latency 3 read");

    // R2: unused length code acts as 1
    load_mode(6, 0, 2, 0);
    read_chk(13, "R2 reserved length code");

    // R8: single-beat writes, reads still burst
    load_mode(2, 0, 2, 1);
    write_burst(9);
    read_chk(8, "R8 single write, burst read");

    // R9: truncation, burst 8 sequential latency 2
    load_mode(3, 0, 2, 0);
    s1 = 16; s2 = 40;
    cmd = 2'd2; addr = 10'(s1); step();
    cmd = 2'd0; step();
    chk(dq_out == mdl[s1], "R9 old beat 0", int'(dq_out), int'(mdl[s1]));
    cmd = 2'd2; addr = 10'(s2); step();
    cmd = 2'd0;
    chk(dq_out == mdl[s1 + 1], "R9 old beat 1", int'(dq_out), int'(mdl[s1 + 1]));
    for (int i = 0; i < 8; i++) begin
      step();
      c = exp_col(s2, i, 8, 0);
      chk(dq_oe == 1'b1 && dq_out == mdl[c], "R9 new burst beat", int'(dq_out), int'(mdl[c]));
    end
    step();
    chk(dq_oe == 1'b0, "R6 oe after truncated run", int'(dq_oe), 0);

    // R10/R11: suspend during a burst 4 read
    load_mode(2, 0, 2, 0);
    cmd = 2'd2; addr = 10'd32; step();
    cmd = 2'd0; step();
    chk(dq_out == mdl[32], "R11 beat 0 before suspend", int'(dq_out), int'(mdl[32]));
    cke = 1'b0; step();
    chk(dq_out == mdl[33], "R10 edge after first low still runs", int'(dq_out), int'(mdl[33]));
    cmd = 2'd3; addr = 10'd33; dq_in = 16'hDEAD; step();
    chk(dq_oe == 1'b1 && dq_out == mdl[33], "R10 held on frozen edge", int'(dq_out), int'(mdl[33]));
    cke = 1'b1; cmd = 2'd0; step();
    chk(dq_oe == 1'b1 && dq_out == mdl[33], "R10 held second frozen edge", int'(dq_out), int'(mdl[33]));
    step();
    chk(dq_out == mdl[34], "R11 resume beat 2", int'(dq_out), int'(mdl[34]));
    step();
    chk(dq_out == mdl[35], "R11 resume beat 3", int'(dq_out), int'(mdl[35]));
    step();
    chk(dq_oe == 1'b0, "R6 oe after suspended burst", int'(dq_oe), 0);
    read_chk(32, "R10 frozen WRITE ignored");

    // R12: enable low while idle does not block commands
    cke = 1'b0;
    load_mode(0, 0, 2, 0);
    write_burst(20);
    cke = 1'b1;
    step();
    read_chk(20, "R12 idle command accepted");

    // random mix, R3/R4/R5/R7/R8
    for (int it = 0; it < 40; it++) begin
      load_mode(int'($urandom_range(3, 0)), 1'($urandom), ($urandom_range(1, 0) != 0) ? 3 : 2,
                1'($urandom));
      write_burst(int'($urandom_range(63, 0)));
      read_chk(int'($urandom_range(63, 0)), "R5 random read");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule